// File: doc/BRIEF.md
# Mesh-Edge Test Access Periphery

This block sits on one side of a two-dimensional mesh and joins an external tester to the border routers on that side. In the inbound direction it takes test flits from the single tester input and steers each whole packet to one border router. A configuration register picks that router, which is the one acting as the access point. The register can be rewritten at any time. A write that lands while a packet is still crossing is parked and takes effect once that packet's last flit has gone through.

In the outbound direction it gathers response packets leaving the border routers toward the edge and merges them onto the one tester output. A round-robin arbiter chooses among the routers that have a packet waiting. Once a head flit is accepted, the output belongs to that router until the packet's final flit, so packets never interleave. The destination identifier of the packet being forwarded is shown beside the output data so the tester can match each response. Every port uses a valid/ready handshake, and ready travels combinationally from the chosen sink back to its source. The number of attached routers is a parameter, either 4 or 2.

Top module: `tap_edge_periph`

## Requirements
- R1: After reset the inbound path feeds router 0, no packet holds either path, and the first free outbound arbitration gives router 0 the highest priority.
- R2: Inbound valid is raised only on the selected router and only while the tester input is valid. The flit passes unchanged, and the tester-side ready equals the selected router's ready in the same cycle.
- R3: A configuration write made while no inbound packet is in flight takes effect at that clock edge, so flits in the next cycle go to the newly selected router.
- R4: A packet is 1 plus the 3-bit length field at bits [20:18] of its head flit, giving 1 to 8 flits. Both paths free their packet state after exactly that many accepted flits.
- R5: A configuration write made while an inbound packet is in flight is held until that packet's last flit is accepted, and only then changes the selection. A later write made while one is held replaces the held value.
- R6: When no packet holds the output, it presents the first valid router after the most recently granted one, searching upward in index order and wrapping around.
- R7: Only the router currently shown on the tester output sees ready, and its ready equals the tester's ready. Every other router sees ready low.
- R8: After a head flit is accepted, the tester output carries only that router's valid and data until the packet's last flit is accepted.
- R9: The destination output equals bits [28:25] of the head flit of the packet being forwarded, and it is held through all flits of that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Router index to use for inbound traffic |
| tin_valid | input | 1 | Tester input flit valid |
| tin_ready | output | 1 | Tester input flit accepted |
| tin_data | input | 32 | Tester input flit |
| rin_valid | output | NUM_RTR | Valid toward each border router input |
| rin_ready | input | NUM_RTR | Ready from each border router input |
| rin_data | output | NUM_RTR*32 | Flit toward each border router input |
| rout_valid | input | NUM_RTR | Valid from each border router edge output |
| rout_ready | output | NUM_RTR | Ready to each border router edge output |
| rout_data | input | NUM_RTR*32 | Flit from each border router edge output |
| tout_valid | output | 1 | Tester output flit valid |
| tout_ready | input | 1 | Tester output flit accepted |
| tout_data | output | 32 | Tester output flit |
| tout_dst | output | 4 | Destination identifier of the forwarded packet |

## Verification
The bench builds the block with four routers, which is the variant where the round-robin wrap and the pointer walk over several indices can actually be seen. All four sources compete at once while the tester ready stalls at random, so both the free and the held arbiter states are exercised. On the inbound side, random packet lengths from 1 to 8 flits are mixed with frequent random configuration writes. This places writes on idle cycles, on head flits, on middle flits, on last flits, and on top of an already parked write.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int FLIT_W  = 32;
  localparam int LEN_LSB = 18;
  localparam int LEN_W   = 3;
  localparam int DST_LSB = 25;
  localparam int DST_W   = 4;

  typedef logic [FLIT_W-1:0] flit_t;

  function automatic logic [LEN_W-1:0] head_len(input flit_t f);
    return f[LEN_LSB +: LEN_W];
  endfunction

  function automatic logic [DST_W-1:0] head_dst(input flit_t f);
    return f[DST_LSB +: DST_W];
  endfunction
endpackage

// File: rtl/tap_pkt_track.sv
module tap_pkt_track
  import tap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [LEN_W-1:0] flit_len,
  output logic             mid_q,
  output logic             last
);
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             mid_d;

  always_comb begin
    mid_d = mid_q;
    rem_d = rem_q;
    last  = 1'b0;
    if (fire) begin
      if (!mid_q) begin
        if (flit_len == '0) begin
          last = 1'b1;
        end else begin
          mid_d = 1'b1;
          rem_d = flit_len;
        end
      end else begin
        rem_d = rem_q - 1'b1;
        if (rem_q == LEN_W'(1)) begin
          mid_d = 1'b0;
          last  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= 1'b0;
      rem_q <= '0;
    end else if (fire) begin
      mid_q <= mid_d;
      rem_q <= rem_d;
    end
  end

  AST_REM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mid_q |-> (rem_q != '0)); // R4
endmodule

// File: rtl/tap_rr_pick.sv
module tap_rr_pick #(
  parameter int NUM_RTR = 4,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_RTR-1:0] req,
  input  logic [SEL_W-1:0]   ptr,
  output logic [SEL_W-1:0]   idx,
  output logic               any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int k = NUM_RTR; k >= 1; k--) begin
      int c;
      c = (int'(ptr) + k) % NUM_RTR;
      if (req[c]) begin
        idx = SEL_W'(c);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tap_in_steer.sv
module tap_in_steer
  import tap_pkg::*;
#(
  parameter int NUM_RTR = 4,
  parameter int SEL_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_wr,
  input  logic [SEL_W-1:0]          cfg_sel,
  input  logic                      tin_valid,
  output logic                      tin_ready,
  input  flit_t                     tin_data,
  output logic [NUM_RTR-1:0]        rin_valid,
  input  logic [NUM_RTR-1:0]        rin_ready,
  output logic [NUM_RTR*FLIT_W-1:0] rin_data
);
  logic             in_fire, in_mid, in_last, busy_nxt;
  logic             want_v;
  logic [SEL_W-1:0] want_s;
  logic [SEL_W-1:0] sel_q, sel_d, psel_q, psel_d;
  logic             pend_q, pend_d;

  assign in_fire   = tin_valid & tin_ready;
  assign tin_ready = rin_ready[sel_q];

  tap_pkt_track u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (in_fire),
    .flit_len (head_len(tin_data)),
    .mid_q    (in_mid),
    .last     (in_last)
  );

  assign busy_nxt = in_fire ? !in_last : in_mid;

  always_comb begin
    want_v = cfg_wr | pend_q;
    want_s = cfg_wr ? cfg_sel : psel_q;
    sel_d  = sel_q;
    pend_d = pend_q;
    psel_d = psel_q;
    if (want_v) begin
      if (!busy_nxt) begin
        sel_d  = want_s;
        pend_d = 1'b0;
      end else begin
        pend_d = 1'b1;
        psel_d = want_s;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      pend_q <= 1'b0;
      psel_q <= '0;
    end else if (want_v) begin
      sel_q  <= sel_d;
      pend_q <= pend_d;
      psel_q <= psel_d;
    end
  end

  for (genvar r = 0; r < NUM_RTR; r++) begin : g_out
    assign rin_valid[r]                 = tin_valid && (sel_q == SEL_W'(r));
    assign rin_data[r*FLIT_W +: FLIT_W] = tin_data;
  end

  AST_IN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rin_valid)); // R2
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mid && !in_last) |=> $stable(sel_q)); // R5
  AST_WRITE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && in_mid && !in_last) |=> pend_q); // R5
endmodule

// File: rtl/tap_out_merge.sv
module tap_out_merge
  import tap_pkg::*;
#(
  parameter int NUM_RTR = 4,
  parameter int SEL_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_RTR-1:0]        rout_valid,
  output logic [NUM_RTR-1:0]        rout_ready,
  input  logic [NUM_RTR*FLIT_W-1:0] rout_data,
  output logic                      tout_valid,
  input  logic                      tout_ready,
  output flit_t                     tout_data,
  output logic [DST_W-1:0]          tout_dst
);
  flit_t             din [NUM_RTR];
  logic [SEL_W-1:0]  gnt_q, ptr_q, pick_idx, cur;
  logic [DST_W-1:0]  dst_q;
  logic              pick_any, lock_q, out_last, out_fire, head_fire;
  logic [NUM_RTR-1:0] gnt_hot;

  for (genvar r = 0; r < NUM_RTR; r++) begin : g_split
    assign din[r] = rout_data[r*FLIT_W +: FLIT_W];
  end

  tap_rr_pick #(.NUM_RTR(NUM_RTR), .SEL_W(SEL_W)) u_pick (
    .req (rout_valid),
    .ptr (ptr_q),
    .idx (pick_idx),
    .any (pick_any)
  );

  assign cur        = lock_q ? gnt_q : pick_idx;
  assign tout_valid = lock_q ? rout_valid[gnt_q] : pick_any;
  assign tout_data  = din[cur];
  assign tout_dst   = lock_q ? dst_q : head_dst(tout_data);
  assign out_fire   = tout_valid & tout_ready;
  assign head_fire  = out_fire & !lock_q;

  tap_pkt_track u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (out_fire),
    .flit_len (head_len(tout_data)),
    .mid_q    (lock_q),
    .last     (out_last)
  );

  for (genvar r = 0; r < NUM_RTR; r++) begin : g_rdy
    assign rout_ready[r] = tout_ready && tout_valid && (cur == SEL_W'(r));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
      ptr_q <= SEL_W'(NUM_RTR - 1);
      dst_q <= '0;
    end else if (head_fire) begin
      gnt_q <= cur;
      ptr_q <= cur;
      dst_q <= head_dst(tout_data);
    end
  end

  assign gnt_hot = NUM_RTR'(1) << gnt_q;

  AST_RDY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rout_ready)); // R7
  AST_RDY_NEEDS_TESTER: assert property (@(posedge clk) disable iff (!rst_n)
    (rout_ready != '0) |-> tout_ready); // R7
  AST_LOCK_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> ((rout_ready & ~gnt_hot) == '0)); // R8
  AST_LOCK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && out_last) |=> !lock_q); // R4
endmodule

// File: rtl/tap_edge_periph.sv
module tap_edge_periph
  import tap_pkg::*;
#(
  parameter  int NUM_RTR = 4,
  localparam int SEL_W   = (NUM_RTR > 1) ? $clog2(NUM_RTR) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_wr,
  input  logic [SEL_W-1:0]          cfg_sel,
  input  logic                      tin_valid,
  output logic                      tin_ready,
  input  logic [FLIT_W-1:0]         tin_data,
  output logic [NUM_RTR-1:0]        rin_valid,
  input  logic [NUM_RTR-1:0]        rin_ready,
  output logic [NUM_RTR*FLIT_W-1:0] rin_data,
  input  logic [NUM_RTR-1:0]        rout_valid,
  output logic [NUM_RTR-1:0]        rout_ready,
  input  logic [NUM_RTR*FLIT_W-1:0] rout_data,
  output logic                      tout_valid,
  input  logic                      tout_ready,
  output logic [FLIT_W-1:0]         tout_data,
  output logic [DST_W-1:0]          tout_dst
);
  tap_in_steer #(.NUM_RTR(NUM_RTR), .SEL_W(SEL_W)) u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .tin_valid (tin_valid),
    .tin_ready (tin_ready),
    .tin_data  (tin_data),
    .rin_valid (rin_valid),
    .rin_ready (rin_ready),
    .rin_data  (rin_data)
  );

  tap_out_merge #(.NUM_RTR(NUM_RTR), .SEL_W(SEL_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .rout_valid (rout_valid),
    .rout_ready (rout_ready),
    .rout_data  (rout_data),
    .tout_valid (tout_valid),
    .tout_ready (tout_ready),
    .tout_data  (tout_data),
    .tout_dst   (tout_dst)
  );
endmodule

// File: tb/tap_edge_periph_bench.sv
module tap_edge_periph_bench;
  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic          tin_valid = 1'b0;
  logic          tin_ready;
  logic [31:0]   tin_data = '0;
  logic [N-1:0]  rin_valid;
  logic [N-1:0]  rin_ready = '0;
  logic [N*32-1:0] rin_data;
  logic [N-1:0]  rv = '0;
  logic [N-1:0]  rout_ready;
  logic [31:0]   rd [N];
  logic [N*32-1:0] rout_data;
  logic          tout_valid;
  logic          tout_ready = 1'b0;
  logic [31:0]   tout_data;
  logic [3:0]    tout_dst;

  assign rout_data = {rd[3], rd[2], rd[1], rd[0]};

  always #2.5 clk = ~clk;

  tap_edge_periph #(.NUM_RTR(N)) u_tap_edge_periph (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .tin_valid(tin_valid), .tin_ready(tin_ready), .tin_data(tin_data),
    .rin_valid(rin_valid), .rin_ready(rin_ready), .rin_data(rin_data),
    .rout_valid(rv), .rout_ready(rout_ready), .rout_data(rout_data),
    .tout_valid(tout_valid), .tout_ready(tout_ready), .tout_data(tout_data),
    .tout_dst(tout_dst)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rr_next(input logic [N-1:0] req, input int ptr);
    for (int k = 1; k <= N; k++) begin
      if (req[(ptr + k) % N]) return (ptr + k) % N;
    end
    return -1;
  endfunction

  // reference model, updated at the falling edge
  int    m_sel, m_ps, m_irem, m_ptr, m_og, m_orem, since_rst;
  bit    m_pv, m_imid, m_lock, m_defer, m_rel;
  logic [3:0] m_dst;
  string m_tag;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_pv = 0; m_ps = 0; m_imid = 0; m_irem = 0; m_defer = 0;
      m_ptr = N - 1; m_lock = 0; m_og = 0; m_orem = 0; m_rel = 0; m_dst = '0;
      m_tag = "R1"; since_rst = 0;
    end else begin
      logic [N-1:0] exp_rv;
      int g;
      bit ev, fire;
      string otag;
      if (since_rst == 0)
        chk(rin_valid == 0 && tout_valid == 0 && rout_ready == 0, "R1 idle after reset",
            {rin_valid, tout_valid, rout_ready}, 32'h0);
      since_rst++;
      // inbound path
      exp_rv = tin_valid ? (N'(1) << m_sel) : '0;
      chk(rin_valid == exp_rv, {m_tag, " inbound valid"}, 32'(rin_valid), 32'(exp_rv));
      if (tin_valid)
        chk(rin_data[m_sel*32 +: 32] == tin_data, "R2 inbound data", rin_data[m_sel*32 +: 32], tin_data);
      chk(tin_ready == rin_ready[m_sel], "R2 inbound ready", 32'(tin_ready), 32'(rin_ready[m_sel]));
      fire = tin_valid && tin_ready;
      if (fire) begin
        if (!m_imid) begin
          if (tin_data[20:18] != 0) begin m_imid = 1; m_irem = int'(tin_data[20:18]); end
        end else begin
          m_irem--;
          if (m_irem == 0) m_imid = 0;
        end
      end
      if (cfg_wr) begin
        m_pv = 1; m_ps = int'(cfg_sel);
        if (m_imid) m_defer = 1;
      end
      if (m_pv && !m_imid) begin
        m_sel = m_ps; m_pv = 0;
        m_tag = m_defer ? "R5" : "R3";
        m_defer = 0;
      end
      // outbound path
      if (m_lock) begin g = m_og; ev = rv[g]; otag = "R8"; end
      else begin
        g = rr_next(rv, m_ptr); ev = (g >= 0);
        otag = m_rel ? "R4" : ((since_rst < 40) ? "R1" : "R6");
      end
      chk(tout_valid == ev, {otag, " outbound valid"}, 32'(tout_valid), 32'(ev));
      if (ev) begin
        chk(tout_data == rd[g], {otag, " outbound data"}, tout_data, rd[g]);
        chk(tout_dst == (m_lock ? m_dst : rd[g][28:25]), "R9 destination", 32'(tout_dst),
            32'(m_lock ? m_dst : rd[g][28:25]));
        chk(rout_ready == (tout_ready ? (N'(1) << g) : '0), "R7 router ready", 32'(rout_ready),
            32'(tout_ready ? (N'(1) << g) : '0));
      end else begin
        chk(rout_ready == 0, "R7 router ready idle", 32'(rout_ready), 32'h0);
      end
      m_rel = 0;
      if (ev && tout_ready) begin
        if (!m_lock) begin
          m_ptr = g;
          if (rd[g][20:18] != 0) begin
            m_lock = 1; m_og = g; m_orem = int'(rd[g][20:18]); m_dst = rd[g][28:25];
          end
        end else begin
          m_orem--;
          if (m_orem == 0) begin m_lock = 0; m_rel = 1; end
        end
      end
    end
  end

  // stimulus
  initial begin
    int t_left, t_len, t_idx, cyc;
    int r_left [N];
    int r_len  [N];
    int r_idx  [N];
    bit tfire, busy, timeout;
    logic [N-1:0] rfire;
    void'($urandom(32'h1A2B3C4D));
    for (int r = 0; r < N; r++) begin rd[r] = '0; r_left[r] = 60; r_len[r] = 0; r_idx[r] = 0; end
    t_left = 200; t_len = 0; t_idx = 0; cyc = 0; timeout = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    busy = 1;
    while (busy) begin
      @(negedge clk);
      tfire = tin_valid && tin_ready;
      rfire = rv & rout_ready;
      @(posedge clk);
      #1;
      cyc++;
      // tester input
      if (tin_valid && tfire) begin
        if (t_idx == t_len) tin_valid = 1'b0;
        else begin t_idx++; tin_data = $urandom; end
      end
      if (!tin_valid && t_left > 0 && ($urandom % 3 != 0)) begin
        t_len = $urandom % 8; t_idx = 0;
        tin_data = $urandom; tin_data[20:18] = t_len[2:0];
        tin_valid = 1'b1; t_left--;
      end
      // router edge outputs
      for (int r = 0; r < N; r++) begin
        if (rv[r] && rfire[r]) begin
          if (r_idx[r] == r_len[r]) rv[r] = 1'b0;
          else begin r_idx[r]++; rd[r] = $urandom; end
        end
        if (!rv[r] && r_left[r] > 0 && ($urandom % 4 == 0)) begin
          r_len[r] = $urandom % 8; r_idx[r] = 0;
          rd[r] = $urandom; rd[r][20:18] = r_len[r][2:0]; rd[r][24:21] = 4'(r);
          rv[r] = 1'b1; r_left[r]--;
        end
      end
      cfg_wr     = ($urandom % 6 == 0);
      cfg_sel    = 2'($urandom);
      rin_ready  = N'($urandom);
      tout_ready = ($urandom % 4 != 0);
      busy = (t_left > 0) || tin_valid || (rv != 0);
      for (int r = 0; r < N; r++) if (r_left[r] > 0) busy = 1;
      if (cyc > 20000) begin timeout = 1; busy = 0; end
    end
    cfg_wr = 1'b0; tin_valid = 1'b0; rv = '0;
    repeat (4) @(posedge clk);
    if (timeout) $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + (timeout ? 1 : 0), n_bad + (timeout ? 1 : 0));
    $finish;
  end
endmodule